// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of `WIDTH` bits (4 by default) one bit position per clock. The operands are held in two right-shifting registers, called the accumulator and the addend. A single full adder combines the low bit of each register with a stored carry. Each enabled cycle writes the sum bit into the top of the accumulator, and both registers move one place to the right. After `WIDTH` such cycles the accumulator holds the sum and the carry flip-flop holds the carry out of the top bit.

The addend register takes a new bit at its top on every shift. This lets the next operand stream in while the current addition runs. If shifting then continues without a reload, the stored carry links the next addition to the result of the previous one. Shift cycles need not be consecutive: with shift low and no load, every register holds its value.

A small controller counts shifts since the last load and raises a one-cycle done pulse. It has four states:
- `ST_IDLE`: after reset, before any load.
- `ST_RUN`: counting shifts.
- `ST_DONE`: the one cycle in which done is high.
- `ST_SPENT`: extra shifts are allowed but do not raise done again.

Its transitions are:
- A load moves any state to `ST_RUN` and clears the count.
- The `WIDTH`-th shift in `ST_RUN` moves to `ST_DONE`.
- Without a load, `ST_DONE` always moves to `ST_SPENT`.
- `ST_IDLE` and `ST_SPENT` stay put until a load.

Top module: `serial_adder`

## Requirements
- R1: A cycle with `load_i` high copies `a_par_i` into the accumulator and `b_par_i` into the addend, and clears the carry flip-flop to 0. All three are visible after that clock edge.
- R2: When `load_i` and `shift_i` are both high, the load is performed and no shift occurs.
- R3: On a clock with `shift_i` high and `load_i` low, the accumulator shifts right by one. Its new top bit is the XOR of the old accumulator bit 0, the old addend bit 0 and the stored carry.
- R4: On the same clock, the carry flip-flop takes the majority of those three bits.
- R5: On each such shift, the addend shifts right by one and `b_ser_i` enters its top bit.
- R6: With `shift_i` and `load_i` both low, the accumulator, addend and carry keep their values.
- R7: After `WIDTH` shifts since a load (consecutive or not), `acc_o` equals (A + B) mod 2^WIDTH and `carry_o` equals bit `WIDTH` of A + B.
- R8: `done_o` is high for exactly the one cycle after the clock edge of the `WIDTH`-th shift since the last load. It is low at every other time, including during further shifts made before the next load.
- R9: The serial bits streamed in during an addition, first bit at bit 0, form the next addend. `WIDTH` further shifts without a load then leave sum + that addend + final carry in `acc_o` and `carry_o`.
- R10: After reset, `acc_o` is 0, `carry_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load of both operands, clears carry |
| a_par_i | input | WIDTH | Parallel value for the accumulator |
| b_par_i | input | WIDTH | Parallel value for the addend |
| shift_i | input | 1 | Perform one bit step of the addition |
| b_ser_i | input | 1 | Serial bit entering the top of the addend |
| acc_o | output | WIDTH | Accumulator contents (sum once done) |
| carry_o | output | 1 | Carry flip-flop |
| done_o | output | 1 | One-cycle pulse after the WIDTH-th shift |

## Verification
The bench loads and shifts at the same time. A design that lets the shift win would show a shifted accumulator or a nonzero carry. It inserts idle cycles between shifts: a design that shifts or counts on those cycles would give a wrong sum or an early done. It checks each bit step of a known addition, which catches a carry that fails to clear on load or uses the wrong gate. It also chains a second addition from the streamed-in operand and shifts past the end. Here a done pulse that repeats, or lasts more than one cycle, would be reported. So would an addend that loses its serial input.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_SPENT = 2'd3
    } sa_state_e;
endpackage

// File: rtl/serial_adder_fa.sv
module serial_adder_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);
    always_comb begin
        sum_o  = x_i ^ y_i ^ cin_i;
        cout_o = (x_i & y_i) | (x_i & cin_i) | (y_i & cin_i);
    end
endmodule

// File: rtl/serial_adder_shreg.sv
module serial_adder_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             shift_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] q_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q <= '0;
        end else if (load_i) begin
            q_q <= par_i;
        end else if (shift_i) begin
            q_q <= {ser_i, q_q[WIDTH-1:1]};
        end
    end

    assign q_o = q_q;

    assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> q_o == $past(par_i));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !shift_i) |=> $stable(q_o));

    assert_serial_in_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !load_i) |=> q_o[WIDTH-1] == $past(ser_i));
endmodule

// File: rtl/serial_adder_ctrl.sv
module serial_adder_ctrl
    import serial_adder_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic shift_i,
    output logic done_o
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    sa_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            ST_RUN: begin
                if (load_i) begin
                    cnt_d = '0;
                end else if (shift_i) begin
                    if (cnt_q == LAST) begin
                        state_d = ST_DONE;
                    end
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                done_o = 1'b1;
                if (load_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    state_d = ST_SPENT;
                end
            end
            ST_SPENT: begin
                if (load_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_after_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(shift_i) && !$past(load_i));
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] a_par_i,
    input  logic [WIDTH-1:0] b_par_i,
    input  logic             shift_i,
    input  logic             b_ser_i,
    output logic [WIDTH-1:0] acc_o,
    output logic             carry_o,
    output logic             done_o
);
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] addend_q;
    logic             sum_bit;
    logic             carry_next;
    logic             carry_q;

    serial_adder_fa u_fa (
        .x_i    (acc_q[0]),
        .y_i    (addend_q[0]),
        .cin_i  (carry_q),
        .sum_o  (sum_bit),
        .cout_o (carry_next)
    );

    serial_adder_shreg #(.WIDTH(WIDTH)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_i),
        .par_i   (a_par_i),
        .shift_i (shift_i),
        .ser_i   (sum_bit),
        .q_o     (acc_q)
    );

    serial_adder_shreg #(.WIDTH(WIDTH)) u_addend (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_i),
        .par_i   (b_par_i),
        .shift_i (shift_i),
        .ser_i   (b_ser_i),
        .q_o     (addend_q)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            carry_q <= 1'b0;
        end else if (load_i) begin
            carry_q <= 1'b0;
        end else if (shift_i) begin
            carry_q <= carry_next;
        end
    end

    serial_adder_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_i),
        .shift_i (shift_i),
        .done_o  (done_o)
    );

    assign acc_o   = acc_q;
    assign carry_o = carry_q;

    assert_carry_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !carry_o);

    assert_sum_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !load_i) |=>
            acc_o[WIDTH-1] == ($past(acc_q[0]) ^ $past(addend_q[0]) ^ $past(carry_q)));

    assert_carry_maj_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !load_i) |=>
            carry_o == (($past(acc_q[0]) + $past(addend_q[0]) + $past(carry_q)) >= 2'd2));

    assert_stall_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shift_i && !load_i) |=> $stable(carry_o));
endmodule

// File: tb/serial_adder_tb_top.sv
module serial_adder_tb_top;
    localparam int W = 4;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] a_par = '0;
    logic [W-1:0] b_par = '0;
    logic         shift_i = 1'b0;
    logic         b_ser = 1'b0;
    logic [W-1:0] acc;
    logic         carry;
    logic         done;

    int n_checks = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_adder #(.WIDTH(W)) dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .load_i  (load_i),
        .a_par_i (a_par),
        .b_par_i (b_par),
        .shift_i (shift_i),
        .b_ser_i (b_ser),
        .acc_o   (acc),
        .carry_o (carry),
        .done_o  (done)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic cin);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic ld, input logic sh, input logic ser);
        load_i  = ld;
        shift_i = sh;
        b_ser   = ser;
        @(negedge clk);
    endtask

    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] nxt, input bit gaps);
        logic [W:0]   r1;
        logic [W:0]   r2;
        logic [W-1:0] held;
        a_par = a;
        b_par = b;
        tick(1'b1, 1'b0, 1'b0);
        chk(acc == a, "R1 load acc", acc, a);
        chk(carry == 1'b0, "R1 load carry", carry, 0);
        for (int i = 0; i < W; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                held = acc;
                tick(1'b0, 1'b0, 1'b1);
                chk(acc == held, "R6 stall hold", acc, held);
                chk(done == 1'b0, "R8 no done on stall", done, 0);
            end
            tick(1'b0, 1'b1, nxt[i]);
            if (i < W - 1) chk(done == 1'b0, "R8 early done", done, 0);
        end
        r1 = ref_add(a, b, 1'b0);
        chk(acc == r1[W-1:0], "R7 sum", acc, r1[W-1:0]);
        chk(carry == r1[W], "R7 carry", carry, r1[W]);
        chk(done == 1'b1, "R8 done pulse", done, 1);
        tick(1'b0, 1'b0, 1'b0);
        chk(done == 1'b0, "R8 single pulse", done, 0);
        for (int i = 0; i < W; i++) begin
            tick(1'b0, 1'b1, 1'b0);
            chk(done == 1'b0, "R8 no repeat", done, 0);
        end
        r2 = ref_add(r1[W-1:0], nxt, r1[W]);
        chk(acc == r2[W-1:0], "R9 chained sum", acc, r2[W-1:0]);
        chk(carry == r2[W], "R9 chained carry", carry, r2[W]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(acc == '0, "R10 reset acc", acc, 0);
        chk(carry == 1'b0, "R10 reset carry", carry, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4 bit steps of 5 + 3
        a_par = 4'b0101;
        b_par = 4'b0011;
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0);
        chk(acc == 4'b0010, "R3 step1 acc", acc, 4'b0010);
        chk(carry == 1'b1, "R4 step1 carry", carry, 1);
        tick(1'b0, 1'b1, 1'b0);
        chk(acc == 4'b0001, "R3 step2 acc", acc, 4'b0001);
        chk(carry == 1'b1, "R4 step2 carry", carry, 1);
        tick(1'b0, 1'b1, 1'b0);
        chk(acc == 4'b0000, "R3 step3 acc", acc, 0);
        tick(1'b0, 1'b1, 1'b0);
        chk(acc == 4'b1000, "R7 5+3", acc, 4'b1000);
        chk(carry == 1'b0, "R4 step4 carry", carry, 0);

        // R2 load wins over shift
        a_par = 4'h9;
        b_par = 4'h6;
        tick(1'b1, 1'b1, 1'b1);
        chk(acc == 4'h9, "R2 load priority acc", acc, 4'h9);
        chk(carry == 1'b0, "R2 load priority carry", carry, 0);
        chk(done == 1'b0, "R2 no done", done, 0);

        // directed corners
        run_add(4'hF, 4'h1, 4'hF, 1'b0);
        run_add(4'hF, 4'hF, 4'hF, 1'b1);
        run_add(4'h0, 4'h0, 4'h0, 1'b0);
        run_add(4'h8, 4'h8, 4'h1, 1'b1);

        // R5 R9 R6 random
        for (int k = 0; k < 60; k++) begin
            run_add(W'($urandom), W'($urandom), W'($urandom), 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule